// File: doc/BRIEF.md
# Three-Channel Square Tone Generator

This block produces three square-wave tones and sums them into one small digital amplitude. A processor programs it with I/O writes. Each write carries an 8-bit port address, 8 bits of data and a one-cycle strobe. Three consecutive ports each hold one channel's 6-bit period P. The port after them is the sound control register, with a global enable bit and an effect-mode flag. The effect-mode flag is stored and shown on an output, but it has no other effect.

Tone timing comes from a clock-enable input at the base rate. A prescaler shared by all channels divides it by 2^DIV_LOG2, which is 1024 by default. Each channel has its own down-counter. When the counter expires, the channel's level flips and the counter reloads with 62 - P. A period of 63 stops the channel's clock, so the channel keeps its present level. The three levels are weighted 2, 3 and 4, which approximates steps of 0, +3 and +6 dB. The weighted sum goes to a 4-bit amplitude, which is forced to zero while sound is disabled.

Top module: `sqr3_sound`

## Requirements
- R1: A write to port BASE_ADDR+k (default 0xF8, 0xF9, 0xFA for k = 0, 1, 2) stores data bits 5..0 as the period of channel k+1, and data bits 7..6 are ignored.
- R2: While enabled and with P below 63, a channel's level flips once every (63 - P) x 2^DIV_LOG2 active base ticks.
- R3: The prescaler counts only cycles in which `baseTick` is high, so thinning `baseTick` stretches every tone interval by the same factor, and `ampOut` changes only on a prescaler tick or a control write.
- R4: A period of 63 stops the channel from being clocked, and its level stays at whatever value it had, which may be 1.
- R5: `ampOut` equals 2·L1 + 3·L2 + 4·L3, where Lk is the level of channel k (bit 0 of the decode is channel 1), so the valid codes are 0, 2, 3, 4, 5, 6, 7 and 9.
- R6: A write to port BASE_ADDR+3 (default 0xFB) sets the enable from data bit 1 and the effect flag, shown on `effectFlag`, from data bit 0, and data bits 7..2 are ignored.
- R7: While the enable is 0, `ampOut` is 0 and channel counters and levels hold. Re-enabling resumes with the stored periods and levels.
- R8: A new period takes effect at the channel's next reload: the count already running finishes with the old value, and the phase is not reset.
- R9: Writes to any address outside BASE_ADDR..BASE_ADDR+3 change neither periods, enable nor effect flag.
- R10: After reset, sound is disabled, the effect flag is 0, and all periods, counters and levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Clock enable at the base tone rate |
| ioWrite | input | 1 | One-cycle I/O write strobe |
| ioAddr | input | 8 | I/O port address |
| ioData | input | 8 | I/O write data |
| ampOut | output | 4 | Weighted sum of active channel levels |
| effectFlag | output | 1 | Stored effect-mode bit |

## Verification
The hardest state to reach from the ports is a chosen set of channels held high at the same time. Only tone toggling moves a level, and a level can only be held by freezing its channel. The bench first freezes every channel with period 63 and then enables sound. Next it releases one channel at a time with period 62, waits for that channel's first flip at the amplitude output, and freezes it again at once. This walks `ampOut` through 4, 7 and 9, which checks each weight and the hold behaviour. The same held state is then used to show that disable silences the output without losing the levels.

// File: rtl/sqr3_pkg.sv
package sqr3_pkg;
  localparam int PER_W = 6;  // period field width
  localparam int IDX_W = 4;  // channel index width in the strobe bundle

  typedef struct packed {
    logic             preTick;   // shared prescaler expiry
    logic             sndOn;     // global enable
    logic             perWrite;  // period write this cycle
    logic [IDX_W-1:0] perIdx;    // target channel of the period write
    logic [PER_W-1:0] perVal;    // new period value
  } toneCtrl_t;
endpackage

// File: rtl/sqr3_ctrl.sv
module sqr3_ctrl
  import sqr3_pkg::*;
#(
  parameter int         NUM_CH    = 3,
  parameter int         DIV_LOG2  = 10,
  parameter logic [7:0] BASE_ADDR = 8'hF8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      baseTick,
  input  logic      ioWrite,
  input  logic [7:0] ioAddr,
  input  logic [7:0] ioData,
  output toneCtrl_t strobes,
  output logic      effectFlag
);
  localparam logic [7:0] CTRL_ADDR = BASE_ADDR + 8'(NUM_CH);

  logic [DIV_LOG2-1:0] preCnt;
  logic                sndOn;
  logic [7:0]          addrOff;
  logic                chanHit;
  logic                ctrlHit;
  logic [7:0]          unusedOff;

  // prescaler advances only on active base ticks
  always_ff @(posedge clk) begin
    if (!rst_n)        preCnt <= '0;
    else if (baseTick) preCnt <= preCnt + 1'b1;
  end

  assign addrOff   = ioAddr - BASE_ADDR;
  assign chanHit   = ioWrite && (ioAddr >= BASE_ADDR) && (ioAddr < CTRL_ADDR);
  assign ctrlHit   = ioWrite && (ioAddr == CTRL_ADDR);
  assign unusedOff = {addrOff[7:IDX_W], {IDX_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sndOn      <= 1'b0;
      effectFlag <= 1'b0;
    end else if (ctrlHit) begin
      sndOn      <= ioData[1];
      effectFlag <= ioData[0];
    end
  end

  always_comb begin
    strobes.preTick  = baseTick && (preCnt == '1);
    strobes.sndOn    = sndOn;
    strobes.perWrite = chanHit;
    strobes.perIdx   = addrOff[IDX_W-1:0];
    strobes.perVal   = ioData[PER_W-1:0];
  end
endmodule

// File: rtl/sqr3_chan.sv
module sqr3_chan
  import sqr3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preTick,
  input  logic             sndOn,
  input  logic             perWrite,
  input  logic [PER_W-1:0] perVal,
  output logic             level
);
  localparam logic [PER_W-1:0] FREEZE     = '1;
  localparam logic [PER_W-1:0] RELOAD_TOP = FREEZE - 1'b1;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] cnt;
  logic             advance;

  assign advance = preTick && sndOn && (period != FREEZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      cnt    <= '0;
      level  <= 1'b0;
    end else begin
      if (perWrite) period <= perVal;
      if (advance) begin
        if (cnt == '0) begin
          cnt   <= RELOAD_TOP - period;
          level <= ~level;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sqr3_datapath.sv
module sqr3_datapath
  import sqr3_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AMP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  toneCtrl_t        strobes,
  output logic [AMP_W-1:0] ampOut
);
  logic [NUM_CH-1:0] levels;
  logic [AMP_W-1:0]  mixSum;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic wrThis;
    assign wrThis = strobes.perWrite && (strobes.perIdx == IDX_W'(g));
    sqr3_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .preTick (strobes.preTick),
      .sndOn   (strobes.sndOn),
      .perWrite(wrThis),
      .perVal  (strobes.perVal),
      .level   (levels[g])
    );
  end

  // channel k weighs k+2: about 0, +3, +6 dB for three channels
  always_comb begin
    mixSum = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (levels[i]) mixSum = mixSum + AMP_W'(i + 2);
    end
  end

  assign ampOut = strobes.sndOn ? mixSum : '0;
endmodule

// File: rtl/sqr3_sound.sv
module sqr3_sound
  import sqr3_pkg::*;
#(
  parameter int         NUM_CH    = 3,
  parameter int         DIV_LOG2  = 10,
  parameter int         AMP_W     = 4,
  parameter logic [7:0] BASE_ADDR = 8'hF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baseTick,
  input  logic             ioWrite,
  input  logic [7:0]       ioAddr,
  input  logic [7:0]       ioData,
  output logic [AMP_W-1:0] ampOut,
  output logic             effectFlag
);
  toneCtrl_t strobes;
  logic [1:0] unusedData;

  assign unusedData = ioData[7:6];

  sqr3_ctrl #(
    .NUM_CH   (NUM_CH),
    .DIV_LOG2 (DIV_LOG2),
    .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .baseTick  (baseTick),
    .ioWrite   (ioWrite),
    .ioAddr    (ioAddr),
    .ioData    (ioData),
    .strobes   (strobes),
    .effectFlag(effectFlag)
  );

  sqr3_datapath #(
    .NUM_CH(NUM_CH),
    .AMP_W (AMP_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .ampOut (ampOut)
  );
endmodule

// File: rtl/sqr3_sound_chk.sv
module sqr3_sound_chk
  import sqr3_pkg::*;
#(
  parameter int         NUM_CH    = 3,
  parameter int         AMP_W     = 4,
  parameter logic [7:0] BASE_ADDR = 8'hF8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baseTick,
  input logic             ioWrite,
  input logic [7:0]       ioAddr,
  input logic [7:0]       ioData,
  input logic [AMP_W-1:0] ampOut,
  input logic             effectFlag,
  input toneCtrl_t        strobes
);
  localparam logic [7:0] CTRL_ADDR = BASE_ADDR + 8'(NUM_CH);
  localparam int         MAX_AMP   = 2 * NUM_CH + (NUM_CH * (NUM_CH - 1)) / 2;

  logic ctrlWr;
  logic strayWr;
  assign ctrlWr  = ioWrite && (ioAddr == CTRL_ADDR);
  assign strayWr = ioWrite && ((ioAddr < BASE_ADDR) || (ioAddr > CTRL_ADDR));

  // R7: silent while disabled
  a_r7_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.sndOn |-> (ampOut == '0));

  // R6: control write sets enable and effect flag
  a_r6_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr |=> (strobes.sndOn == $past(ioData[1])) && (effectFlag == $past(ioData[0])));

  // R9: stray addresses leave control state alone
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    strayWr |=> $stable(strobes.sndOn) && $stable(effectFlag));

  // R3: no prescaler tick without a base tick
  a_r3_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !baseTick |-> !strobes.preTick);

  // R3: output steady between ticks and control writes
  a_r3_steady_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.preTick && !ctrlWr) |=> $stable(ampOut));

  // R5: output stays within the weighted range, never the unreachable code 1
  a_r5_amp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ampOut <= AMP_W'(MAX_AMP)) && (ampOut != AMP_W'(1)));
endmodule

bind sqr3_sound sqr3_sound_chk #(
  .NUM_CH   (NUM_CH),
  .AMP_W    (AMP_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baseTick  (baseTick),
  .ioWrite   (ioWrite),
  .ioAddr    (ioAddr),
  .ioData    (ioData),
  .ampOut    (ampOut),
  .effectFlag(effectFlag),
  .strobes   (strobes)
);

// File: tb/sqr3_sound_tb.sv
module sqr3_sound_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int TICKS      = 1 << DIV;
  localparam int MAXWAIT    = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baseTick = 1'b1;
  logic       ioWrite = 1'b0;
  logic [7:0] ioAddr = 8'h00;
  logic [7:0] ioData = 8'h00;
  logic [3:0] ampOut;
  logic       effectFlag;

  int checks = 0;
  int failures = 0;
  int baseDiv = 1;
  int phase = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqr3_sound #(.DIV_LOG2(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioData(ioData), .ampOut(ampOut), .effectFlag(effectFlag)
  );

  // base tick pattern: every baseDiv-th cycle
  always @(negedge clk) begin
    if (baseDiv <= 1) baseTick <= 1'b1;
    else begin
      phase = (phase + 1) % baseDiv;
      baseTick <= (phase == 0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R5 decode: bit0 = ch1, bit1 = ch2, bit2 = ch3, bit3 = code valid
  function automatic logic [3:0] decode(input logic [3:0] a);
    case (a)
      4'd0: return 4'b1000;
      4'd2: return 4'b1001;
      4'd3: return 4'b1010;
      4'd4: return 4'b1100;
      4'd5: return 4'b1011;
      4'd6: return 4'b1101;
      4'd7: return 4'b1110;
      4'd9: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic chBit(input int ch);
    logic [3:0] d;
    d = decode(ampOut);
    return d[ch];
  endfunction

  task automatic wrPort(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWrite = 1'b1; ioAddr = a; ioData = d;
    @(negedge clk);
    ioWrite = 1'b0; ioAddr = 8'h00; ioData = 8'h00;
  endtask

  task automatic waitChange(input int ch, output int waited);
    logic prev;
    prev = chBit(ch);
    waited = 0;
    while (waited < MAXWAIT) begin
      @(negedge clk);
      waited++;
      if (!decode(ampOut)[3]) check(0, "R5 invalid amplitude code", ampOut, 0);
      if (chBit(ch) != prev) return;
    end
    waited = -1;
  endtask

  task automatic measure(input int ch, output int iv);
    int w;
    waitChange(ch, w);
    waitChange(ch, iv);
  endtask

  task automatic holdCheck(input int cycles, input logic [3:0] exp, input string tag);
    bit ok = 1'b1;
    logic [3:0] bad = exp;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ampOut != exp) begin ok = 1'b0; bad = ampOut; end
    end
    check(ok, tag, bad, exp);
  endtask

  task automatic t_reset();
    check(ampOut == 4'd0, "R10 reset amplitude", ampOut, 0);
    check(effectFlag == 1'b0, "R10 reset effect flag", effectFlag, 0);
  endtask

  // freeze all, then raise channels one by one: R4, R5, R1
  task automatic t_weights_freeze();
    int w;
    wrPort(8'hF8, 8'h3F); wrPort(8'hF9, 8'h3F); wrPort(8'hFA, 8'h3F);
    wrPort(8'hFB, 8'h02);
    holdCheck(3 * TICKS, 4'd0, "R4 all frozen at level 0");
    wrPort(8'hFA, 8'd62);
    waitChange(2, w);
    wrPort(8'hFA, 8'h3F);
    holdCheck(4 * TICKS, 4'd4, "R5 channel 3 weight / R4 hold high");
    wrPort(8'hF9, 8'd62);
    waitChange(1, w);
    wrPort(8'hF9, 8'h3F);
    holdCheck(4 * TICKS, 4'd7, "R5 channels 2+3 weight");
    wrPort(8'hF8, 8'hFE);  // R1: upper bits ignored, P = 62
    measure(0, w);
    check(w == TICKS, "R1 upper data bits ignored, interval", w, TICKS);
    waitChange(0, w);
    wrPort(8'hF8, 8'h3F);
    holdCheck(4 * TICKS, 4'd9, "R5 all channels weight");
  endtask

  // R6, R7: disable silences, keeps levels; effect flag stored
  task automatic t_disable();
    wrPort(8'hFB, 8'hFD);
    check(ampOut == 4'd0, "R7 disabled output zero", ampOut, 0);
    check(effectFlag == 1'b1, "R6 effect flag set", effectFlag, 1);
    holdCheck(5 * TICKS, 4'd0, "R7 stays silent");
    wrPort(8'hFB, 8'h02);
    check(ampOut == 4'd9, "R7 levels held across disable", ampOut, 9);
    check(effectFlag == 1'b0, "R6 effect flag cleared", effectFlag, 0);
  endtask

  // R2: interval for several periods
  task automatic t_periods();
    int w;
    wrPort(8'hF9, 8'd60);
    measure(1, w);
    check(w == 3 * TICKS, "R2 P=60 interval", w, 3 * TICKS);
    wrPort(8'hF9, 8'h3F);
    wrPort(8'hFA, 8'hF7);  // P = 55
    measure(2, w);
    check(w == 8 * TICKS, "R2 P=55 interval", w, 8 * TICKS);
    wrPort(8'hFA, 8'h3F);
  endtask

  // R3: thinned base tick stretches interval
  task automatic t_basegate();
    int w;
    wrPort(8'hF8, 8'd62);
    baseDiv = 2;
    measure(0, w);
    check(w == 2 * TICKS, "R3 half-rate base tick interval", w, 2 * TICKS);
    baseDiv = 1;
    measure(0, w);
    check(w == TICKS, "R3 full-rate interval restored", w, TICKS);
  endtask

  // R8: period change applies at next reload
  task automatic t_phase();
    int w;
    int w2;
    waitChange(0, w);
    wrPort(8'hF8, 8'd60);
    waitChange(0, w2);
    check(w2 + 2 == TICKS, "R8 running count keeps old period", w2 + 2, TICKS);
    waitChange(0, w);
    check(w == 3 * TICKS, "R8 new period after reload", w, 3 * TICKS);
  endtask

  // R9: stray addresses ignored
  task automatic t_ignore();
    int w;
    wrPort(8'hFB, 8'h03);
    wrPort(8'hFC, 8'h00);
    wrPort(8'hF7, 8'h00);
    wrPort(8'hFF, 8'h00);
    check(effectFlag == 1'b1, "R9 effect flag unchanged", effectFlag, 1);
    measure(0, w);
    check(w == 3 * TICKS, "R9 still enabled, period unchanged", w, 3 * TICKS);
  endtask

  // R7: re-enable keeps stored period
  task automatic t_reenable();
    int w;
    wrPort(8'hFB, 8'h00);
    holdCheck(6 * TICKS, 4'd0, "R7 silent while off");
    wrPort(8'hFB, 8'h02);
    measure(0, w);
    check(w == 3 * TICKS, "R7 stored period after re-enable", w, 3 * TICKS);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_weights_freeze();
    t_disable();
    t_periods();
    t_basegate();
    t_phase();
    t_ignore();
    t_reenable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule